// File: doc/BRIEF.md
# Bit-Slip Word Aligner

The block realigns a deserialized stream to its true word boundary. Every clock cycle it accepts one W-bit parallel word. It joins the two most recent words of its history into a 2W-bit value, with the newer word in the upper half and the older word in the lower half. It then emits a W-bit window taken from that value at a bit offset chosen by the slip input.

A link-training controller that finds the correct offset drives the slip input. The slip value is expected to stay constant during normal traffic. The data path has a fixed four-cycle latency. After reset the history is all zeros, so the first outputs are windows over zero words until real data reaches the older slot.

The data width W must be a power of two and at least 2. The slip input is log2(W) bits wide.

Top module: `bitslip_aligner`

## Requirements
- R1: The output word equals the low W bits of the 2W-bit value {newer, older}, shifted right logically by the applied slip amount; the newer word occupies bits [2W-1:W].
- R2: The output seen during cycle n is built with the input of cycle n-3 as the newer word and the input of cycle n-4 as the older word.
- R3: With a slip amount of 0, the output equals the input delayed by exactly four cycles.
- R4: Every slip value from 0 to W-1 is supported, including the largest value W-1.
- R5: The slip input is registered once. A slip value presented in cycle n is applied to the output of cycle n+2, and each output word is formed with a single slip amount.
- R6: rst_n is synchronous and active low. A clock edge with rst_n low clears the output, the slip register and all history registers, so the output reads 0 in the following cycle.
- R7: After reset the history is zero-filled. The first three outputs after release are 0, and the fourth output uses an all-zero older word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| slip | input | log2(W) | Bit offset of the output window |
| din | input | W | Parallel input word, one per cycle |
| dout | output | W | Realigned output word |

## Verification
Each output is due four cycles after the word that forms its lower half is presented, and three cycles after the word that forms its upper half. A slip change shows up two cycles after it is presented, and a reset edge zeroes the output in the very next cycle. The bench keeps a short cycle-indexed log of the applied words, slip values and the last reset edge. From that log it computes the expected output for each cycle and samples the output at the falling edge, midway between the edges that could change it. The checker module uses the same offsets: 3 and 4 cycles back for data and 2 for slip, gated by a count of edges since reset.

// File: rtl/bsa_pkg.sv
`timescale 1ns/1ps
// Package bsa_pkg
// Shared constants and helpers for the bit-slip aligner.
// Assumes: the data width is a power of two and at least 2.
package bsa_pkg;

    // Number of history words held ahead of the output register.
    localparam int HIST_DEPTH = 3;

    // Total input-to-output latency in cycles.
    localparam int LATENCY = HIST_DEPTH + 1;

    // Width of the slip index for a given data width.
    function automatic int slip_width(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/bsa_delay_line.sv
`timescale 1ns/1ps
// Module bsa_delay_line
// A chain of DEPTH word registers. Tap g holds the input from g+1 cycles ago.
// Assumes: synchronous active-low reset that clears every stage to zero.
module bsa_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          din,
    output logic [DEPTH-1:0][W-1:0] taps
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic [W-1:0] src;
        logic [W-1:0] q;

        if (g == 0) begin : g_head
            assign src = din;
        end else begin : g_link
            assign src = g_stage[g-1].q;
        end

        // Shift one word along the chain per cycle; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= src;
        end

        assign taps[g] = q;
    end

endmodule

// File: rtl/bsa_window_mux.sv
`timescale 1ns/1ps
// Module bsa_window_mux
// Picks one of W fixed windows from the joined pair {newer, older}.
// Candidate k is bits [k+W-1:k] of the pair, so each candidate is plain wiring
// and the only logic is one W-way selector per output bit.
// Assumes: W is a power of two, so every value of sel names a candidate.
module bsa_window_mux #(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input  logic [W-1:0]  newer,
    input  logic [W-1:0]  older,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  window
);

    logic [2*W-1:0] joined;
    logic [W-1:0]   cand [W];

    assign joined = {newer, older};

    for (genvar k = 0; k < W; k++) begin : g_cand
        assign cand[k] = joined[k +: W];
    end

    // Select the candidate named by the slip index.
    always_comb begin
        window = cand[sel];
    end

endmodule

// File: rtl/bitslip_aligner.sv
`timescale 1ns/1ps
// Module bitslip_aligner (top)
// Realigns a parallel word stream by a programmable bit offset. The output in
// cycle n is the W-bit window at offset slip of {din[n-3], din[n-4]}.
// Assumes: W is a power of two, at least 2; synchronous active-low reset.
module bitslip_aligner #(
    parameter  int W  = 16,
    localparam int SW = bsa_pkg::slip_width(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slip,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    localparam int DEPTH = bsa_pkg::HIST_DEPTH;

    logic [DEPTH-1:0][W-1:0] hist;
    logic [SW-1:0]           slip_q;
    logic [W-1:0]            window;

    bsa_delay_line #(
        .W     (W),
        .DEPTH (DEPTH)
    ) u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .taps  (hist)
    );

    // Capture the slip amount once so each word uses a single offset.
    always_ff @(posedge clk) begin
        if (!rst_n) slip_q <= '0;
        else        slip_q <= slip;
    end

    bsa_window_mux #(
        .W      (W),
        .SW     (SW)
    ) u_mux (
        .newer  (hist[DEPTH-2]),
        .older  (hist[DEPTH-1]),
        .sel    (slip_q),
        .window (window)
    );

    // Register the selected window as the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= window;
    end

endmodule

// File: rtl/bitslip_aligner_chk.sv
`timescale 1ns/1ps
// Module bitslip_aligner_chk
// Port-level timing checks for bitslip_aligner, attached with bind.
// Assumes: the run counter counts clock edges since the last reset edge.
module bitslip_aligner_chk #(
    parameter int W  = 16,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [SW-1:0] slip,
    input logic [W-1:0]  din,
    input logic [W-1:0]  dout
);

    logic [2:0] run_cnt = '0;

    // Count edges with reset released, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n)               run_cnt <= '0;
        else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
    end

    function automatic logic [W-1:0] ref_win(input logic [W-1:0] hi,
                                             input logic [W-1:0] lo,
                                             input logic [SW-1:0] s);
        logic [2*W-1:0] t;
        t = {hi, lo} >> s;
        return t[W-1:0];
    endfunction

    // R6: a reset edge zeroes the output in the next cycle.
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> dout == '0);

    // R1, R2, R5: window from data 3 and 4 cycles back, slip 2 cycles back.
    a_r1_window: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 3'd4) |-> dout == ref_win($past(din, 3), $past(din, 4), $past(slip, 2)));

    // R3: slip 0 gives a pure four-cycle delay.
    a_r3_slip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 3'd4 && $past(slip, 2) == '0) |-> dout == $past(din, 4));

    // R7: the first three outputs after release are zero.
    a_r7_leading_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt < 3'd3) |-> dout == '0);

    // R7: the fourth output uses a zero older word.
    a_r7_zero_older: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 3'd3) |-> dout == ref_win($past(din, 3), '0, $past(slip, 2)));

endmodule

bind bitslip_aligner bitslip_aligner_chk #(
    .W  (W),
    .SW (SW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .slip  (slip),
    .din   (din),
    .dout  (dout)
);

// File: tb/sim_bitslip_aligner.sv
`timescale 1ns/1ps
// Bench for bitslip_aligner: a vector table walk, then seeded random runs for
// every slip value, slip toggling and a mid-run reset, all checked against a
// cycle-indexed log of the applied inputs.
module sim_bitslip_aligner;

    localparam int W  = 16;
    localparam int SW = 4;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] slip = '0;
    logic [W-1:0]  din = '0;
    logic [W-1:0]  dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int            cyc = 0;
    int            last_rst = 0;
    logic [W-1:0]  din_log [8];
    logic [SW-1:0] slip_log [8];
    logic [31:0]   lfsr = 32'd42;

    // Entries are {din, slip, expected dout in that cycle}, from reset release.
    localparam logic [35:0] TBL [NV] = '{
        {16'h1234, 4'd4, 16'h0000},
        {16'hABCD, 4'd4, 16'h0000},
        {16'h0F0F, 4'd4, 16'h0000},
        {16'hFFFF, 4'd4, 16'h4000},
        {16'h8001, 4'd4, 16'hD123},
        {16'h0000, 4'd4, 16'hFABC},
        {16'h0000, 4'd4, 16'hF0F0},
        {16'h0000, 4'd4, 16'h1FFF},
        {16'h0000, 4'd4, 16'h0800},
        {16'h0000, 4'd4, 16'h0000}
    };

    bitslip_aligner #(.W(W)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .slip  (slip),
        .din   (din),
        .dout  (dout)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge and advance to the next one.
    task automatic tick(input logic r, input logic [W-1:0] d, input logic [SW-1:0] s);
        rst_n = r;
        din   = d;
        slip  = s;
        din_log[cyc % 8]  = d;
        slip_log[cyc % 8] = s;
        if (!r) last_rst = cyc;
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    function automatic logic [W-1:0] rnd();
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        return lfsr[31:16];
    endfunction

    // Expected output in the current cycle, taken from the input log.
    task automatic chk_model();
        logic [W-1:0]   hi, lo;
        logic [SW-1:0]  s, sp;
        logic [2*W-1:0] t;
        string          tag;
        hi = (last_rst < cyc - 3) ? din_log[(cyc - 3) % 8] : '0;
        lo = (last_rst < cyc - 4) ? din_log[(cyc - 4) % 8] : '0;
        s  = (last_rst < cyc - 2) ? slip_log[(cyc - 2) % 8] : '0;
        sp = (last_rst < cyc - 3) ? slip_log[(cyc - 3) % 8] : '0;
        t  = {hi, lo} >> s;
        if (last_rst >= cyc - 1)       t = '0;
        if (last_rst >= cyc - 4)       tag = "R7";
        else if (s != sp)              tag = "R5";
        else if (s == '0)              tag = "R3";
        else if (s == SW'(W - 1))      tag = "R4";
        else                           tag = "R1";
        chk(dout, t[W-1:0], tag);
    endtask

    initial begin
        @(negedge clk);
        tick(1'b0, '0, '0);
        tick(1'b0, '0, '0);
        chk(dout, '0, "R6 reset state");
        tick(1'b0, 16'hFFFF, 4'd7);

        // R2: table of directed vectors right after reset release.
        for (int i = 0; i < NV; i++) begin
            chk(dout, TBL[i][15:0], "R2");
            tick(1'b1, TBL[i][35:20], TBL[i][19:16]);
        end

        // R1, R3, R4: every slip value over a seeded random stream.
        for (int s = 0; s < W; s++) begin
            for (int j = 0; j < 130; j++) begin
                chk_model();
                tick(1'b1, rnd(), SW'(s));
            end
        end

        // R5: slip toggling every cycle between the extremes.
        for (int j = 0; j < 24; j++) begin
            chk_model();
            tick(1'b1, rnd(), (j % 2 == 0) ? '0 : SW'(W - 1));
        end

        // R6, R7: mid-run reset, then zero-filled restart at slip 5.
        chk_model();
        tick(1'b0, rnd(), 4'd9);
        chk(dout, '0, "R6 mid-run reset");
        for (int j = 0; j < 8; j++) begin
            chk_model();
            tick(1'b1, rnd(), 4'd5);
        end
        chk_model();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule